// File: doc/BRIEF.md
# Low-Charge Alert Interrupt Controller

This block watches the state-of-charge word produced by a fuel-gauge engine and raises a host interrupt when the integer percentage of charge drops under a programmable threshold. It holds a sticky alert flag and an active-low interrupt level, `irq_n`, meant to drive an open-drain pad. The flag stays set until host software clears it. Once cleared, the block stays quiet until the charge has gone back up to the threshold or above.

The threshold is a 5-bit field held in a small register. Its reset value gives 4%. The field is decoded as 32 minus the field value, so the usable range runs from 1% to 32%. Each new charge result arrives with a one-cycle valid strobe, and only those cycles are compared. A sleep input freezes the comparison path. It leaves any pending alert in place.

The core is a four-state machine:
- `ST_ARMED`: no flag, armed.
- `ST_ALERT`: flag set, disarmed.
- `ST_ALERT_REARMED`: flag set, armed again because a sample reached the threshold.
- `ST_HOLDOFF`: flag cleared while the charge is still low, disarmed.

Transitions:
- ARMED→ALERT on a low sample.
- ALERT→ALERT_REARMED on a sample at or above the threshold.
- ALERT→ARMED on a clear together with a sample at or above the threshold.
- ALERT→HOLDOFF on a clear alone.
- ALERT_REARMED→ALERT on a low sample, with or without a clear.
- ALERT_REARMED→ARMED on a clear alone.
- HOLDOFF→ARMED on a sample at or above the threshold.

Top module: `low_charge_alert`

## Requirements
- R1: After reset `alert_flag` is 0, `irq_n` is 1 and the threshold field holds 1Ch (4%), so a sample of 0x0400 does not alert and 0x0380 does.
- R2: A threshold write (`thr_wr` high) loads `thr_wdata` on that clock edge. The effective threshold is 32 minus the field value: field 00000b gives 32%, field 11111b gives 1%.
- R3: The charge is compared only on cycles where `soc_valid` is 1. A low `soc_word` with `soc_valid` at 0 never sets the flag.
- R4: A sample is low when `soc_word[15:8]`, the integer percent, is strictly less than the threshold. The low byte has no effect. A low sample while armed sets `alert_flag` to 1 on the next cycle.
- R5: Once set, `alert_flag` stays 1 whatever samples arrive, until a `flag_clr` pulse.
- R6: After a clear, further low samples do not set the flag again until the block has been re-armed.
- R7: A sample whose integer percent is greater than or equal to the threshold re-arms the block. The next low sample raises the flag again.
- R8: When `flag_clr` and a firing low sample fall in the same cycle, the flag ends up set.
- R9: The first sample after reset raises the alert if it is low.
- R10: While `sleep_i` is 1, samples are ignored and a set flag is held.
- R11: `irq_n` is always the inverse of `alert_flag`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| soc_word | input | 16 | Charge word: integer percent in bits 15:8, fraction in bits 7:0 |
| soc_valid | input | 1 | One-cycle strobe marking a new charge word |
| sleep_i | input | 1 | Low-power state: comparisons halted |
| thr_wr | input | 1 | Threshold field write strobe |
| thr_wdata | input | 5 | New threshold field (percent = 32 - value) |
| flag_clr | input | 1 | Host write that clears the alert flag |
| alert_flag | output | 1 | Sticky alert flag |
| irq_n | output | 1 | Active-low interrupt; 0 means the pad is pulled low |

## Verification
Two events can land on the same edge: a host clear and a new low sample that fires the alert. The bench first drives the block into the flagged-and-rearmed state. It then raises `flag_clr` and `soc_valid` with a low `soc_word` in the same cycle, and expects the flag to remain set. As a contrast, a clear alone in that same state is expected to drop the flag, and the next low sample is expected to raise it again.

// File: rtl/lca_pkg.sv
package lca_pkg;
    typedef enum logic [1:0] {
        ST_ARMED         = 2'd0,
        ST_ALERT         = 2'd1,
        ST_ALERT_REARMED = 2'd2,
        ST_HOLDOFF       = 2'd3
    } lca_state_e;
endpackage

// File: rtl/lca_thr_reg.sv
module lca_thr_reg #(
    parameter int unsigned THR_W   = 5,
    parameter logic [THR_W-1:0] THR_RST = 5'h1C
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             thr_wr,
    input  logic [THR_W-1:0] thr_wdata,
    output logic [THR_W-1:0] thr_code,
    output logic [THR_W:0]   thr_pct
);
    localparam int unsigned PCT_MAX = 1 << THR_W;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)      thr_code <= THR_RST;
        else if (thr_wr) thr_code <= thr_wdata;
    end

    // inverted field: percent = 2^THR_W - code
    assign thr_pct = (THR_W+1)'(PCT_MAX) - {1'b0, thr_code};

    AST_THR_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
        thr_wr |=> thr_code == $past(thr_wdata)); // R2
endmodule

// File: rtl/lca_cmp.sv
module lca_cmp #(
    parameter int unsigned SOC_W = 16,
    parameter int unsigned INT_W = 8,
    parameter int unsigned THR_W = 5
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [SOC_W-1:0] soc_word,
    input  logic             soc_valid,
    input  logic             sleep_i,
    input  logic [THR_W:0]   thr_pct,
    output logic             smp_below,
    output logic             smp_above
);
    localparam int unsigned CMP_W = (INT_W > THR_W + 1) ? INT_W : THR_W + 1;

    logic [INT_W-1:0] soc_int;
    logic [CMP_W-1:0] soc_x, thr_x;
    logic             qual;

    assign soc_int = soc_word[SOC_W-1 -: INT_W];
    assign soc_x   = CMP_W'(soc_int);
    assign thr_x   = CMP_W'(thr_pct);
    assign qual    = soc_valid & ~sleep_i;

    always_comb begin
        smp_below = qual && (soc_x <  thr_x);
        smp_above = qual && (soc_x >= thr_x);
    end

    AST_SLEEP_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        sleep_i |-> !(smp_below || smp_above)); // R10
endmodule

// File: rtl/lca_fsm.sv
module lca_fsm
    import lca_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic smp_below,
    input  logic smp_above,
    input  logic flag_clr,
    output logic alert_flag,
    output logic irq_n
);
    lca_state_e state, state_nx;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= ST_ARMED;
        else        state <= state_nx;
    end

    always_comb begin
        state_nx = state;
        unique case (state)
            ST_ARMED: begin
                if (smp_below) state_nx = ST_ALERT;
            end
            ST_ALERT: begin
                if (smp_above)     state_nx = flag_clr ? ST_ARMED : ST_ALERT_REARMED;
                else if (flag_clr) state_nx = ST_HOLDOFF;
            end
            ST_ALERT_REARMED: begin
                if (smp_below)     state_nx = ST_ALERT;   // trigger beats clear
                else if (flag_clr) state_nx = ST_ARMED;
            end
            ST_HOLDOFF: begin
                if (smp_above) state_nx = ST_ARMED;
            end
            default: state_nx = ST_ARMED;
        endcase
    end

    always_comb begin
        alert_flag = 1'b0;
        irq_n      = 1'b1;
        unique case (state)
            ST_ALERT, ST_ALERT_REARMED: begin
                alert_flag = 1'b1;
                irq_n      = 1'b0;
            end
            default: begin
                alert_flag = 1'b0;
                irq_n      = 1'b1;
            end
        endcase
    end

    AST_ARMED_FIRES: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_ARMED && smp_below) |=> alert_flag); // R4
    AST_FLAG_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        (alert_flag && !flag_clr) |=> alert_flag); // R5
    AST_HOLDOFF_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_HOLDOFF) |=> !alert_flag); // R6
    AST_REARM_FIRES: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_ALERT_REARMED && smp_below) |=> (state == ST_ALERT)); // R7
    AST_TRIGGER_WINS: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_ALERT_REARMED && smp_below && flag_clr) |=> alert_flag); // R8
endmodule

// File: rtl/low_charge_alert.sv
module low_charge_alert #(
    parameter int unsigned SOC_W = 16,
    parameter int unsigned INT_W = 8,
    parameter int unsigned THR_W = 5,
    parameter logic [THR_W-1:0] THR_RST = 5'h1C
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [SOC_W-1:0] soc_word,
    input  logic             soc_valid,
    input  logic             sleep_i,
    input  logic             thr_wr,
    input  logic [THR_W-1:0] thr_wdata,
    input  logic             flag_clr,
    output logic             alert_flag,
    output logic             irq_n
);
    logic [THR_W-1:0] thr_code;
    logic [THR_W:0]   thr_pct;
    logic             smp_below, smp_above;

    lca_thr_reg #(.THR_W(THR_W), .THR_RST(THR_RST)) u_thr (
        .clk(clk), .rst_n(rst_n), .thr_wr(thr_wr), .thr_wdata(thr_wdata),
        .thr_code(thr_code), .thr_pct(thr_pct)
    );

    lca_cmp #(.SOC_W(SOC_W), .INT_W(INT_W), .THR_W(THR_W)) u_cmp (
        .clk(clk), .rst_n(rst_n), .soc_word(soc_word), .soc_valid(soc_valid),
        .sleep_i(sleep_i), .thr_pct(thr_pct),
        .smp_below(smp_below), .smp_above(smp_above)
    );

    lca_fsm u_fsm (
        .clk(clk), .rst_n(rst_n), .smp_below(smp_below), .smp_above(smp_above),
        .flag_clr(flag_clr), .alert_flag(alert_flag), .irq_n(irq_n)
    );

    AST_NO_UNQUAL_SET: assert property (@(posedge clk) disable iff (!rst_n)
        (!alert_flag && !soc_valid) |=> !alert_flag); // R3
endmodule

// File: tb/tb_low_charge_alert.sv
module tb_low_charge_alert;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [15:0] soc_word = '0;
    logic        soc_valid = 1'b0;
    logic        sleep_i = 1'b0;
    logic        thr_wr = 1'b0;
    logic [4:0]  thr_wdata = '0;
    logic        flag_clr = 1'b0;
    logic        alert_flag, irq_n;

    int n_run = 0;
    int n_fail = 0;

    always #4 clk = ~clk;

    low_charge_alert dut (
        .clk(clk), .rst_n(rst_n), .soc_word(soc_word), .soc_valid(soc_valid),
        .sleep_i(sleep_i), .thr_wr(thr_wr), .thr_wdata(thr_wdata),
        .flag_clr(flag_clr), .alert_flag(alert_flag), .irq_n(irq_n)
    );

    // also covers R11: irq_n must be the inverse of the flag
    task automatic check(input string req, input logic exp_flag);
        n_run++;
        if (alert_flag !== exp_flag || irq_n !== ~exp_flag) begin
            n_fail++;
            $display("FAIL %s: flag=%b irq_n=%b expected flag=%b irq_n=%b",
                     req, alert_flag, irq_n, exp_flag, ~exp_flag);
        end
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0; soc_valid = 1'b0; flag_clr = 1'b0; thr_wr = 1'b0; sleep_i = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
    endtask

    task automatic sample(input logic [15:0] v);
        @(negedge clk);
        soc_word = v; soc_valid = 1'b1;
        @(negedge clk);
        soc_valid = 1'b0;
    endtask

    task automatic clear();
        @(negedge clk);
        flag_clr = 1'b1;
        @(negedge clk);
        flag_clr = 1'b0;
    endtask

    task automatic write_thr(input logic [4:0] v);
        @(negedge clk);
        thr_wdata = v; thr_wr = 1'b1;
        @(negedge clk);
        thr_wr = 1'b0;
    endtask

    task automatic t_reset();
        do_reset();
        check("R1 reset state", 1'b0);
        check("R11 reset pin released", 1'b0);
    endtask

    task automatic t_first_sample();
        do_reset();
        sample(16'h0200);
        check("R9 first low sample alerts", 1'b1);
    endtask

    task automatic t_default_thr();
        do_reset();
        sample(16'h04FF);
        check("R1 default 4% not crossed by 0x04FF", 1'b0);
        sample(16'h03FF);
        check("R4 low byte ignored, 3% alerts", 1'b1);
    endtask

    task automatic t_sticky();
        sample(16'h6400);
        check("R5 high sample keeps flag", 1'b1);
        repeat (5) @(negedge clk);
        check("R5 flag held while idle", 1'b1);
    endtask

    task automatic t_holdoff_rearm();
        do_reset();
        sample(16'h0100);
        check("R4 alert at 1%", 1'b1);
        clear();
        check("R6 clear drops flag", 1'b0);
        sample(16'h0000);
        check("R6 no refire while still low", 1'b0);
        sample(16'h0400);
        check("R7 equal sample rearms quietly", 1'b0);
        sample(16'h0300);
        check("R7 refire after rearm", 1'b1);
    endtask

    task automatic t_thr_code();
        do_reset();
        write_thr(5'b00000);
        sample(16'h2000);
        check("R2 field 0 = 32%, 32 not below", 1'b0);
        sample(16'h1FFF);
        check("R2 field 0 = 32%, 31 below", 1'b1);
        clear();
        write_thr(5'b11111);
        sample(16'h0100);
        check("R2 field 1F = 1%, 1 rearms", 1'b0);
        sample(16'h00FF);
        check("R2 field 1F = 1%, 0 below", 1'b1);
    endtask

    task automatic t_valid_gate();
        do_reset();
        @(negedge clk);
        soc_word = 16'h0000;
        repeat (6) @(negedge clk);
        check("R3 no valid, no alert", 1'b0);
    endtask

    task automatic t_collision();
        do_reset();
        sample(16'h0000);
        sample(16'h5000);
        check("R7 rearmed while flagged", 1'b1);
        @(negedge clk);
        soc_word = 16'h0000; soc_valid = 1'b1; flag_clr = 1'b1;
        @(negedge clk);
        soc_valid = 1'b0; flag_clr = 1'b0;
        check("R8 trigger wins over clear", 1'b1);
        sample(16'h5000);
        clear();
        check("R8 clear alone in rearmed state", 1'b0);
        sample(16'h0000);
        check("R7 refire after clear in rearmed state", 1'b1);
    endtask

    task automatic t_sleep();
        do_reset();
        sample(16'h0000);
        @(negedge clk);
        sleep_i = 1'b1;
        repeat (4) @(negedge clk);
        check("R10 sleep keeps pending alert", 1'b1);
        do_reset();
        @(negedge clk);
        sleep_i = 1'b1;
        sample(16'h0000);
        check("R10 sample ignored in sleep", 1'b0);
        @(negedge clk);
        sleep_i = 1'b0;
        sample(16'h0000);
        check("R10 sample after wake alerts", 1'b1);
    endtask

    bit done = 1'b0;

    initial begin
        t_reset();
        t_first_sample();
        t_default_thr();
        t_sticky();
        t_holdoff_rearm();
        t_thr_code();
        t_valid_gate();
        t_collision();
        t_sleep();
        if (!done) begin
            done = 1'b1;
            $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            n_run++;
            n_fail++;
            $display("FAIL watchdog: run hung, expected completion");
            $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end
endmodule